// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Result Queue

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter with eight inputs. A start pulse latches a channel number, which goes out on a 3-bit selector to the external analog multiplexer. A fixed sampling interval follows. The block then makes eight trials, most significant bit first. Each trial drives a code onto the external DAC and reads one comparator bit back.

Every conversion lasts the same number of input clocks. The interval after sampling is split evenly across the eight trials, and any cycles left over form a short settle phase before the result is ready. Finished results go into a three-entry queue. The CPU reads the queue one entry at a time from a data port. The block provides a not-empty flag, a one-cycle interrupt pulse for each stored result, and a sticky overrun flag for results dropped because the queue was full.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy, not-empty, overrun and interrupt are all 0, and the DAC code is 0x00.
- R2: A start pulse seen while idle latches the channel, which appears on the selector one cycle later. Busy then stays high for exactly 160 cycles.
- R3: The DAC code is 0x00 whenever the block is idle and during the 12 sampling cycles. The first trial code, 0x80, appears 12 cycles after busy rises.
- R4: Trials run from bit 7 down to bit 0 and each trial lasts 18 cycles. The code for trial k is the bits already kept, plus bit 7-k set. A bit is kept when the comparator input is 1, meaning the analog input is at or above the trial code. With an ideal comparator the result equals the analog input value.
- R5: After the last trial, a 4-cycle settle phase holds the final result on the DAC.
- R6: A result is stored in the cycle in which busy falls. In that same cycle the interrupt is high for one cycle and not-empty is 1.
- R7: A start pulse while busy has no effect. The selector, the conversion length and the result of the running conversion are unchanged.
- R8: The data port shows the oldest stored result. A read pulse removes it, so results come out in conversion order.
- R9: A result that finishes while three entries are stored, with no read in that cycle, is dropped. No interrupt is raised, the stored entries are kept, and the overrun flag is set and stays set.
- R10: A clear pulse resets the overrun flag.
- R11: A read pulse while the queue is empty is ignored, and later results are stored and read normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start pulse |
| chan_i | input | 3 | Channel to convert |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| mux_sel_o | output | 3 | Analog multiplexer selector |
| dac_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| rd_i | input | 1 | Read pulse: remove the oldest result |
| clr_ovr_i | input | 1 | Clear pulse for the overrun flag |
| rd_data_o | output | 8 | Oldest stored result |
| not_empty_o | output | 1 | At least one result stored |
| overrun_o | output | 1 | Sticky flag: a result was dropped |
| irq_o | output | 1 | One-cycle pulse for each stored result |

## Verification
A wrong phase counter shows up within one trial. The DAC code would change on the wrong cycle, or busy would not fall exactly 160 cycles after it rose. A corrupt bit mask or keep decision produces a wrong trial code that is visible on the DAC at the start of the next trial. It also gives a wrong result on the data port. Queue pointer or count faults show only when entries are read back: values come out of order, not-empty changes at the wrong time, or overrun sets too early or too late.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_SETTLE = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CH_W       = 3,
  parameter int SAMP_CYC   = 12,
  parameter int TRIAL_CYC  = 18,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MAX_A = (SAMP_CYC > TRIAL_CYC) ? SAMP_CYC : TRIAL_CYC;
  localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SAMP_LD   = CNT_W'(SAMP_CYC - 1);
  localparam logic [CNT_W-1:0] TRIAL_LD  = CNT_W'(TRIAL_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'((SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0);
  localparam logic [DATA_W-1:0] TOP_BIT  = {1'b1, {(DATA_W-1){1'b0}}};

  phase_t              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   mask_q;
  logic [DATA_W-1:0]   dac_q;
  logic [CH_W-1:0]     sel_q;
  logic                cnt_zero;
  logic [DATA_W-1:0]   trial_code;

  assign cnt_zero   = (cnt_q == '0);
  // keep the trial bit only when the comparator says input >= code
  assign trial_code = cmp_i ? dac_q : (dac_q & ~mask_q);

  assign done_o   = ((phase_q == PH_SETTLE) && cnt_zero) ||
                    ((SETTLE_CYC == 0) && (phase_q == PH_TRIAL) && cnt_zero && mask_q[0]);
  assign result_o = (phase_q == PH_SETTLE) ? dac_q : trial_code;
  assign busy_o    = (phase_q != PH_IDLE);
  assign mux_sel_o = sel_q;
  assign dac_o     = dac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mask_q  <= '0;
      dac_q   <= '0;
      sel_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= SAMP_LD;
            sel_q   <= chan_i;
          end
        end
        PH_SAMPLE: begin
          if (cnt_zero) begin
            phase_q <= PH_TRIAL;
            cnt_q   <= TRIAL_LD;
            mask_q  <= TOP_BIT;
            dac_q   <= TOP_BIT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_TRIAL: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!mask_q[0]) begin
            mask_q <= mask_q >> 1;
            dac_q  <= trial_code | (mask_q >> 1);
            cnt_q  <= TRIAL_LD;
          end else if (SETTLE_CYC > 0) begin
            phase_q <= PH_SETTLE;
            cnt_q   <= SETTLE_LD;
            dac_q   <= trial_code;
            mask_q  <= '0;
          end else begin
            phase_q <= PH_IDLE;
            dac_q   <= '0;
            mask_q  <= '0;
          end
        end
        default: begin
          if (cnt_zero) begin
            phase_q <= PH_IDLE;
            dac_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_fifo.sv
module sar_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int DATA_W   = 8,
  parameter int CH_W     = 3,
  parameter int CONV_CYC = 160,
  parameter int SAMP_CYC = 12,
  parameter int Q_DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              cmp_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              busy_o,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              not_empty_o,
  output logic              overrun_o,
  output logic              irq_o
);
  localparam int TRIAL_CYC  = (CONV_CYC - SAMP_CYC) / DATA_W;
  localparam int SETTLE_CYC = CONV_CYC - SAMP_CYC - TRIAL_CYC * DATA_W;

  logic              done;
  logic [DATA_W-1:0] result;
  logic              q_full, q_empty;
  logic              drop, push;
  logic              irq_q, ovr_q;

  sar_ctrl #(
    .DATA_W(DATA_W), .CH_W(CH_W), .SAMP_CYC(SAMP_CYC),
    .TRIAL_CYC(TRIAL_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .cmp_i(cmp_i),
    .busy_o(busy_o), .mux_sel_o(mux_sel_o), .dac_o(dac_o),
    .done_o(done), .result_o(result)
  );

  // a finishing result is lost only if the queue is full and not read now
  assign drop = done && q_full && !rd_i;
  assign push = done && !drop;

  sar_fifo #(.WIDTH(DATA_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push), .din_i(result), .pop_i(rd_i),
    .head_o(rd_data_o), .full_o(q_full), .empty_o(q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      irq_q <= push;
      if (drop)           ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;
    end
  end

  assign irq_o       = irq_q;
  assign overrun_o   = ovr_q;
  assign not_empty_o = !q_empty;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int DATA_W   = 8,
  parameter int CH_W     = 3,
  parameter int CONV_CYC = 160
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic [DATA_W-1:0] dac_o,
  input logic [CH_W-1:0]   mux_sel_o,
  input logic              irq_o,
  input logic              not_empty_o,
  input logic              overrun_o
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else     run_len <= busy_o ? run_len + 1'b1 : '0;
  end

  p_dac_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> dac_o == '0);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> run_len == 16'(CONV_CYC));

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_irq_ne_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> not_empty_o);

  p_end_push_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (irq_o || overrun_o));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(
  .DATA_W(DATA_W), .CH_W(CH_W), .CONV_CYC(CONV_CYC)
) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .dac_o(dac_o),
  .mux_sel_o(mux_sel_o), .irq_o(irq_o), .not_empty_o(not_empty_o),
  .overrun_o(overrun_o)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] chan = '0;
  logic       cmp;
  logic [2:0] mux_sel;
  logic [7:0] dac;
  logic       busy;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] rd_data;
  logic       not_empty, overrun, irq;
  logic [7:0] ain [8];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign cmp = (ain[mux_sel] >= dac);

  sar_adc_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start), .chan_i(chan), .cmp_i(cmp),
    .mux_sel_o(mux_sel), .dac_o(dac), .busy_o(busy), .rd_i(rd),
    .clr_ovr_i(clr), .rd_data_o(rd_data), .not_empty_o(not_empty),
    .overrun_o(overrun), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] trial_code(input logic [7:0] v, input int k);
    logic [7:0] keep_mask;
    keep_mask = ~((8'd1 << (8 - k)) - 8'd1);
    return (v & keep_mask) | (8'd1 << (7 - k));
  endfunction

  task automatic run_conv(input logic [2:0] ch, input bit exp_push,
                          input bit trace, input bit inject);
    logic [7:0] v;
    v = ain[ch];
    @(negedge clk); start = 1'b1; chan = ch;
    @(negedge clk); start = 1'b0;
    for (int m = 1; m <= 161; m++) begin
      if (m > 1) @(negedge clk);
      if (inject && m == 50) begin start = 1'b1; chan = ch ^ 3'd7; end
      if (inject && m == 51) start = 1'b0;
      if (m == 1)   check("R2", "busy rises", 32'(busy), 1);
      if (m == 1)   check("R2", "selector", 32'(mux_sel), 32'(ch));
      if (m == 160) check("R2", "busy at 160", 32'(busy), 1);
      if (m == 161) check("R2", "busy falls", 32'(busy), 0);
      if (m == 161) check("R6", "irq at end", 32'(irq), 32'(exp_push));
      if (inject && m == 100) check("R7", "selector held", 32'(mux_sel), 32'(ch));
      if (trace) begin
        if (m == 12) check("R3", "dac in sampling", 32'(dac), 0);
        for (int k = 0; k < 8; k++)
          if (m == 13 + 18 * k) check("R4", "trial code", 32'(dac), 32'(trial_code(v, k)));
        if (m == 30) check("R4", "trial 0 length", 32'(dac), 32'(trial_code(v, 0)));
        if (m == 157) check("R5", "settle start", 32'(dac), 32'(v));
        if (m == 160) check("R5", "settle end", 32'(dac), 32'(v));
        if (m == 161) check("R3", "dac idle", 32'(dac), 0);
      end
    end
    @(negedge clk);
    check("R6", "irq single cycle", 32'(irq), 0);
  endtask

  task automatic read_one(input string req, input logic [7:0] exp);
    check(req, "not empty", 32'(not_empty), 1);
    check(req, "read data", 32'(rd_data), 32'(exp));
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "not empty", 32'(not_empty), 0);
    check("R1", "overrun", 32'(overrun), 0);
    check("R1", "irq", 32'(irq), 0);
    check("R1", "dac", 32'(dac), 0);
  endtask

  task automatic t_single;
    run_conv(3'd3, 1'b1, 1'b1, 1'b0);
    check("R6", "not empty after end", 32'(not_empty), 1);
    read_one("R8", ain[3]);
    check("R8", "empty after read", 32'(not_empty), 0);
  endtask

  task automatic t_patterns;
    run_conv(3'd0, 1'b1, 1'b1, 1'b0); read_one("R4", ain[0]);
    run_conv(3'd7, 1'b1, 1'b1, 1'b0); read_one("R4", ain[7]);
    run_conv(3'd4, 1'b1, 1'b1, 1'b0); read_one("R4", ain[4]);
  endtask

  task automatic t_ignore;
    run_conv(3'd2, 1'b1, 1'b1, 1'b1);
    read_one("R7", ain[2]);
    check("R7", "no second conversion", 32'(busy), 0);
  endtask

  task automatic t_overrun;
    run_conv(3'd1, 1'b1, 1'b0, 1'b0);
    run_conv(3'd5, 1'b1, 1'b0, 1'b0);
    run_conv(3'd6, 1'b1, 1'b0, 1'b0);
    check("R9", "no overrun at three", 32'(overrun), 0);
    run_conv(3'd0, 1'b0, 1'b0, 1'b0);
    check("R9", "overrun set", 32'(overrun), 1);
    read_one("R8", ain[1]);
    read_one("R8", ain[5]);
    read_one("R9", ain[6]);
    check("R9", "dropped entry absent", 32'(not_empty), 0);
    check("R9", "overrun sticky", 32'(overrun), 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R10", "overrun cleared", 32'(overrun), 0);
  endtask

  task automatic t_empty_read;
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check("R11", "still empty", 32'(not_empty), 0);
    run_conv(3'd3, 1'b1, 1'b0, 1'b0);
    read_one("R11", ain[3]);
    check("R11", "empty again", 32'(not_empty), 0);
  endtask

  initial begin
    ain[0] = 8'h00; ain[1] = 8'h11; ain[2] = 8'h3C; ain[3] = 8'hA5;
    ain[4] = 8'h80; ain[5] = 8'h5A; ain[6] = 8'h7F; ain[7] = 8'hFF;
    t_reset();
    t_single();
    t_patterns();
    t_ignore();
    t_overrun();
    t_empty_read();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule